// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler and Phase Shaping

This block produces the serial clock of an I2C master. A programmable prescaler first divides the input clock down to a slower module tick. The tick rate is intended to sit roughly between 7 and 12 MHz. Two programmable counts, one for the low phase and one for the high phase, then set the length of each serial clock period in module ticks. Each phase lasts its programmed count plus a fixed extra delay. That extra delay depends on the prescaler setting, unless a variant strap pins it to one value.

Software computes the divider values and applies them while the block is disabled. The values are captured while the enable is low and take effect when the block leaves the disabled state. The clock output is an open-drain pull-down request. While that request is released, the generator watches the sampled line and counts high time only while the line really is high, so a slave that holds the clock low stretches the period. A byte engine uses two one-cycle strobes: one marks each falling edge, where it may change the data line, and one marks the middle of each high phase, where it samples the data line.

Top module: `scl_clkgen`

## Requirements
- R1: While `enable` is low, `scl_drive_low`, `tick_fall` and `tick_mid` are 0 from the next clock on, and all counters are cleared. After a disable in the middle of a phase, a fresh enable shows the same start-up latency as the first one.
- R2: The module tick occurs once every PSC+1 input clocks, where PSC is the value on `psc_in`. After the first clock edge that samples `enable` high, `scl_drive_low` stays 0 for exactly PSC cycles and then goes to 1.
- R3: Every low phase (`scl_drive_low` = 1) lasts (LO + d) x (PSC+1) input clocks, where LO is `low_cnt`.
- R4: When the line is not held low by another device, every high phase lasts (HI + d) x (PSC+1) input clocks, where HI is `high_cnt`. HI = 0 gives exactly d x (PSC+1).
- R5: With `d_fixed` = 0, d is 7 for PSC = 0, 6 for PSC = 1 and 5 for PSC of 2 or more.
- R6: With `d_fixed` = 1, d is 6 for every PSC.
- R7: `psc_in`, `low_cnt`, `high_cnt` and `d_fixed` are captured only while `enable` is low. Changes to them while enabled do not alter any phase length until the next disable and enable.
- R8: During a high phase, the count advances only on module ticks where `scl_sense` is 1. Each module tick with `scl_sense` = 0 lengthens the high phase by one module tick.
- R9: `tick_fall` is a one-cycle pulse in the first cycle of every low phase. `tick_mid` is one one-cycle pulse per high phase, in high-phase cycle floor((HI+d)/2) x (PSC+1) + 1 counted from 1, plus any stretch ticks that came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable from the controller; low holds the block in its disabled state |
| psc_in | input | PSC_W | Prescaler value PSC |
| low_cnt | input | CNT_W | Low-phase count LO |
| high_cnt | input | CNT_W | High-phase count HI |
| d_fixed | input | 1 | Variant strap; 1 forces the extra delay to 6 |
| scl_sense | input | 1 | Sampled serial clock line level |
| scl_drive_low | output | 1 | 1 = pull the serial clock line low; 0 = release it |
| tick_fall | output | 1 | One-cycle strobe at each falling edge |
| tick_mid | output | 1 | One-cycle strobe in the middle of each high phase |

## Verification
Clock stretching is the hardest behaviour to reach, because the line input must go low exactly while the block itself has released it. The bench models the line as a wired-AND of the block's pull-down and a slave hold flag. It raises the hold flag in the first cycle after each release and drops it a set number of cycles later. The bench then checks that both the high-phase length and the position of the mid strobe move by that amount. A second hard case is a configuration change while the block is running. The bench changes every configuration input in the middle of a low phase and checks that the following phases keep the old lengths, and that the new values apply only after the next disable and enable.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    localparam int DLY_W = 3;

    localparam logic [DLY_W-1:0] DLY_PSC_ZERO = 3'd7;
    localparam logic [DLY_W-1:0] DLY_PSC_ONE  = 3'd6;
    localparam logic [DLY_W-1:0] DLY_PSC_MANY = 3'd5;
    localparam logic [DLY_W-1:0] DLY_STRAPPED = 3'd6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow
    import scl_clkgen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             d_fixed,
    output logic [PSC_W-1:0] psc_s,
    output logic [CNT_W-1:0] lo_s,
    output logic [CNT_W-1:0] hi_s,
    output logic [DLY_W-1:0] dly_s
);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [DLY_W-1:0] dly;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [DLY_W-1:0] dly_pick;

    // extra delay chosen from the incoming prescaler value or the strap
    always_comb begin
        if (d_fixed)
            dly_pick = DLY_STRAPPED;
        else if (psc_in == '0)
            dly_pick = DLY_PSC_ZERO;
        else if (psc_in == PSC_W'(1))
            dly_pick = DLY_PSC_ONE;
        else
            dly_pick = DLY_PSC_MANY;
    end

    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.psc = psc_in;
            cfg_d.lo  = low_cnt;
            cfg_d.hi  = high_cnt;
            cfg_d.dly = dly_pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '{psc: '0, lo: '0, hi: '0, dly: DLY_PSC_ZERO};
        else
            cfg_q <= cfg_d;
    end

    assign psc_s = cfg_q.psc;
    assign lo_s  = cfg_q.lo;
    assign hi_s  = cfg_q.hi;
    assign dly_s = cfg_q.dly;

    // R7: while running, the captured configuration never moves
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_q));

    // R5 / R6: the delay is always one of the three legal values
    p_dly_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.dly >= DLY_PSC_MANY) && (cfg_q.dly <= DLY_PSC_ZERO));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_s,
    output logic             mod_tick
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    assign mod_tick = enable && (pre_q.cnt == psc_s);

    always_comb begin
        pre_d = pre_q;
        if (!enable)
            pre_d.cnt = '0;
        else if (mod_tick)
            pre_d.cnt = '0;
        else
            pre_d.cnt = pre_q.cnt + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else
            pre_q <= pre_d;
    end

    // R2: the divider count never passes the prescaler value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (pre_q.cnt <= psc_s));

    // R2: with PSC above zero, two ticks are never adjacent
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_tick && (psc_s != '0) && enable) |=> !mod_tick);

    // R1: the divider is cleared while disabled
    p_cleared_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pre_q.cnt == '0));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mod_tick,
    input  logic             scl_sense,
    input  logic [CNT_W-1:0] lo_s,
    input  logic [CNT_W-1:0] hi_s,
    input  logic [DLY_W-1:0] dly_s,
    output logic             scl_low,
    output logic             fall_stb,
    output logic             mid_stb
);

    localparam int CW = CNT_W + 1;

    typedef struct packed {
        phase_e        state;
        logic [CW-1:0] cnt;
        logic          low;
        logic          fall;
        logic          mid;
    } ph_t;

    ph_t ph_d, ph_q;

    logic [CW-1:0] lim_lo, lim_hi, half_hi;

    assign lim_lo  = {1'b0, lo_s} + CW'(dly_s);
    assign lim_hi  = {1'b0, hi_s} + CW'(dly_s);
    assign half_hi = lim_hi >> 1;

    always_comb begin
        ph_d      = ph_q;
        ph_d.fall = 1'b0;
        ph_d.mid  = 1'b0;
        if (!enable) begin
            ph_d.state = PH_IDLE;
            ph_d.cnt   = '0;
            ph_d.low   = 1'b0;
        end else if (mod_tick) begin
            case (ph_q.state)
                PH_IDLE: begin
                    ph_d.state = PH_LOW;
                    ph_d.cnt   = '0;
                    ph_d.low   = 1'b1;
                    ph_d.fall  = 1'b1;
                end
                PH_LOW: begin
                    if (ph_q.cnt == lim_lo - CW'(1)) begin
                        ph_d.state = PH_HIGH;
                        ph_d.cnt   = '0;
                        ph_d.low   = 1'b0;
                    end else begin
                        ph_d.cnt = ph_q.cnt + CW'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_sense) begin
                        if (ph_q.cnt == lim_hi - CW'(1)) begin
                            ph_d.state = PH_LOW;
                            ph_d.cnt   = '0;
                            ph_d.low   = 1'b1;
                            ph_d.fall  = 1'b1;
                        end else begin
                            ph_d.cnt = ph_q.cnt + CW'(1);
                            if (ph_q.cnt == half_hi - CW'(1))
                                ph_d.mid = 1'b1;
                        end
                    end
                end
                default: begin
                    ph_d.state = PH_IDLE;
                    ph_d.cnt   = '0;
                    ph_d.low   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= '{state: PH_IDLE, cnt: '0, low: 1'b0, fall: 1'b0, mid: 1'b0};
        else
            ph_q <= ph_d;
    end

    assign scl_low  = ph_q.low;
    assign fall_stb = ph_q.fall;
    assign mid_stb  = ph_q.mid;

    // R1: disabling releases the line and silences the strobes
    p_release_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ph_q.low && !ph_q.fall && !ph_q.mid && ph_q.cnt == '0));

    // R9: every start of a low phase carries the fall strobe
    p_fall_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_q.low) |-> ph_q.fall);

    // R9: the mid strobe only appears while the line is released
    p_mid_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.mid |-> !ph_q.low);

    // R8: a held-low line freezes the high-phase count
    p_stretch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mod_tick && ph_q.state == PH_HIGH && !scl_sense)
            |=> (ph_q.cnt == $past(ph_q.cnt)));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             d_fixed,
    input  logic             scl_sense,
    output logic             scl_drive_low,
    output logic             tick_fall,
    output logic             tick_mid
);

    logic [PSC_W-1:0] psc_s;
    logic [CNT_W-1:0] lo_s;
    logic [CNT_W-1:0] hi_s;
    logic [DLY_W-1:0] dly_s;
    logic             mod_tick;

    scl_cfg_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .psc_in   (psc_in),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .d_fixed  (d_fixed),
        .psc_s    (psc_s),
        .lo_s     (lo_s),
        .hi_s     (hi_s),
        .dly_s    (dly_s)
    );

    scl_prescaler #(.PSC_W(PSC_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .psc_s    (psc_s),
        .mod_tick (mod_tick)
    );

    scl_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mod_tick  (mod_tick),
        .scl_sense (scl_sense),
        .lo_s      (lo_s),
        .hi_s      (hi_s),
        .dly_s     (dly_s),
        .scl_low   (scl_drive_low),
        .fall_stb  (tick_fall),
        .mid_stb   (tick_mid)
    );

endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;

    localparam int PSC_W = 4;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [PSC_W-1:0] psc_in = '0;
    logic [CNT_W-1:0] low_cnt = '0;
    logic [CNT_W-1:0] high_cnt = '0;
    logic             d_fixed = 1'b0;
    logic             scl_sense;
    logic             scl_drive_low, tick_fall, tick_mid;
    logic             hold = 1'b0;
    logic             done = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    // wired-AND line: the block's pull-down or a slave holding it low
    assign scl_sense = !scl_drive_low && !hold;

    scl_clkgen #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .psc_in        (psc_in),
        .low_cnt       (low_cnt),
        .high_cnt      (high_cnt),
        .d_fixed       (d_fixed),
        .scl_sense     (scl_sense),
        .scl_drive_low (scl_drive_low),
        .tick_fall     (tick_fall),
        .tick_mid      (tick_mid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_d(input int p, input int s);
        if (s != 0) return 6;
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    task automatic wait_first_low(output int z);
        z = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (scl_drive_low) return;
            z++;
        end
    endtask

    task automatic measure_low(output int len, output int falls);
        len = 1;
        falls = int'(tick_fall);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!scl_drive_low) return;
            len++;
            falls += int'(tick_fall);
        end
    endtask

    task automatic measure_high(input int hold_k, output int len,
                                output int mids, output int midpos);
        len = 1;
        mids = int'(tick_mid);
        midpos = tick_mid ? 1 : 0;
        if (hold_k > 0) hold = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (len == hold_k) hold = 1'b0;
            if (scl_drive_low) return;
            len++;
            if (tick_mid) begin
                mids++;
                midpos = len;
            end
        end
        hold = 1'b0;
    endtask

    task automatic set_cfg(input int p, input int lo, input int hi, input int s);
        psc_in   = PSC_W'(p);
        low_cnt  = CNT_W'(lo);
        high_cnt = CNT_W'(hi);
        d_fixed  = (s != 0);
    endtask

    task automatic run_cfg(input int p, input int lo, input int hi, input int s);
        int z, len, falls, mids, midpos, pp, d, hh;
        pp = p + 1;
        d = exp_d(p, s);
        hh = hi + d;
        enable = 1'b0;
        set_cfg(p, lo, hi, s);
        repeat (2) @(negedge clk);
        chk("R1 released while disabled", int'(scl_drive_low), 0);
        enable = 1'b1;
        wait_first_low(z);
        chk("R2 start latency", z, p);
        chk("R9 first fall strobe", int'(tick_fall), 1);
        measure_low(len, falls);
        chk("R3 low length", len, (lo + d) * pp);
        chk(s != 0 ? "R6 strapped delay" : "R5 delay by prescaler", len / pp - lo, d);
        chk("R9 one fall per low", falls, 1);
        measure_high(0, len, mids, midpos);
        chk("R4 high length", len, hh * pp);
        chk("R9 one mid per high", mids, 1);
        chk("R9 mid position", midpos, (hh / 2) * pp + 1);
        chk("R9 fall strobe at next low", int'(tick_fall), 1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int z, len, falls, mids, midpos;
        repeat (3) @(negedge clk);
        chk("R1 reset drive", int'(scl_drive_low), 0);
        chk("R1 reset fall strobe", int'(tick_fall), 0);
        chk("R1 reset mid strobe", int'(tick_mid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep over a small configuration space
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 2; s++)
                for (int lo = 0; lo < 4; lo += 3)
                    for (int hi = 0; hi < 3; hi += 2)
                        run_cfg(p, lo, hi, s);
        run_cfg(9, 5, 4, 0);

        // R7: change every configuration input while running
        set_cfg(1, 2, 1, 0);
        @(negedge clk);
        enable = 1'b1;
        wait_first_low(z);
        repeat (2) @(negedge clk);
        set_cfg(3, 9, 7, 1);
        measure_low(len, falls);
        chk("R7 low length kept", len + 2, (2 + 6) * 2);
        measure_high(0, len, mids, midpos);
        chk("R7 high length kept", len, (1 + 6) * 2);
        measure_low(len, falls);
        chk("R7 next low kept", len, (2 + 6) * 2);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        wait_first_low(z);
        chk("R7 new prescaler after re-enable", z, 3);
        measure_low(len, falls);
        chk("R7 new low after re-enable", len, (9 + 6) * 4);
        enable = 1'b0;
        @(negedge clk);

        // R8: slave stretches the high phase by 9 cycles
        set_cfg(0, 1, 3, 0);
        @(negedge clk);
        enable = 1'b1;
        wait_first_low(z);
        measure_low(len, falls);
        measure_high(9, len, mids, midpos);
        chk("R8 stretched high length", len, (3 + 7) + 9);
        chk("R8 mid shifted by stretch", midpos, 5 + 9 + 1);
        chk("R8 single mid while stretched", mids, 1);
        measure_low(len, falls);
        chk("R8 low after stretch", len, 1 + 7);
        enable = 1'b0;
        @(negedge clk);

        // R1: disable in mid phase clears counters
        set_cfg(2, 4, 2, 0);
        @(negedge clk);
        enable = 1'b1;
        wait_first_low(z);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 release after mid-phase disable", int'(scl_drive_low), 0);
        chk("R1 no strobe after disable", int'(tick_fall) + int'(tick_mid), 0);
        enable = 1'b1;
        wait_first_low(z);
        chk("R1 counters cleared on re-enable", z, 2);
        measure_low(len, falls);
        chk("R1 full low after re-enable", len, (4 + 5) * 3);
        enable = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule